// File: doc/BRIEF.md
# Parallel Pseudo-Random Dither Word Generator

This block produces a fresh multi-bit pseudo-random word on every enabled clock. The word drives a dither injection path. A single maximal-length linear feedback shift register of 23 bits steps once per enabled cycle.

Each output lane is not a neighbouring tap of that register. Instead, each lane is a fixed XOR of state bits that reproduces the register's own bit stream, shifted forward by a large phase offset. The seven lanes are therefore the same m-sequence seen at widely spaced points of its period. This removes the strong cross-correlation that adjacent taps would carry. The XOR masks are computed at elaboration from the width, the feedback tap and the lane count, so none is written out by hand.

A seed can be loaded at any time. A zero seed is replaced by a fixed non-zero default, so the register can never lock up. When enable is low the generator freezes, and the valid flag marks exactly the cycles that carry a new word.

Top module: `dither_lfsr`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `ditherValid` is 0 and `ditherWord` is 0. After reset, the state equals the default seed, which is 1 (only state bit 0 set).
- R2: State bit k holds sequence element a[t+k]. The sequence obeys a[n+23] = a[n+18] XOR a[n], which is the polynomial x^23 + x^18 + 1. Bit 0 of each valid word is a[t], the element at the state that was current when the word was produced.
- R3: Bit i of each valid word (i = 0..6) equals a[t + i*S], where S = floor((2^23-1)/7) = 1198372.
- R4: The sequence is maximal length. Words repeat after exactly 2^W-1 enabled steps, where W is the register width.
- R5: When `enable` is low and `seedLoad` is low, the state holds, `ditherValid` is 0 in the following cycle, and `ditherWord` keeps its value.
- R6: Each cycle with `enable` high and `seedLoad` low advances the state by exactly one step. In the following cycle, `ditherValid` is 1 and `ditherWord` holds the new word.
- R7: `seedLoad` takes priority over `enable`. It copies `seedIn` into the state, and `ditherValid` is 0 in the following cycle.
- R8: A load of an all-zero `seedIn` puts the default seed (value 1) into the state.
- R9: The state is never all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance the generator by one step this cycle |
| seedLoad | input | 1 | Load `seedIn` into the state this cycle |
| seedIn | input | 23 | Seed value; zero selects the default seed |
| ditherWord | output | 7 | Registered pseudo-random dither word |
| ditherValid | output | 1 | High in the cycle after an advancing step |

## Verification
The sharpest case is the lane phase. Each lane is compared against an independent serial model that is advanced by the lane's offset. A mask built from the wrong power, or from the reciprocal polynomial, would match lane 0 and diverge on every other lane. Enable gaps interleaved with single steps expose a design that skips or repeats a step while paused, or that raises valid without advancing. A load issued while enable is high catches wrong priority. A zero seed catches a register that locks at zero. A narrow 7-bit instance runs a full period, so a non-maximal feedback choice shows up as words that fail to recur after 127 steps.

// File: rtl/dither_lfsr_pkg.sv
package dither_lfsr_pkg;

  // Polynomials over GF(2), bit k is the coefficient of x^k.
  typedef logic [63:0] gfPoly;

  typedef struct packed {
    logic loadSeed;
    logic advance;
  } lfsrStrobe_t;

  // a * b mod (x^w + x^tap + 1)
  function automatic gfPoly mulMod(gfPoly a, gfPoly b, int w, int tap);
    logic [127:0] prod;
    prod = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < w && b[i]) prod = prod ^ ({64'b0, a} << i);
    end
    for (int d = 126; d >= 0; d--) begin
      if (d >= w && prod[d]) begin
        prod[d]           = 1'b0;
        prod[d - w + tap] = ~prod[d - w + tap];
        prod[d - w]       = ~prod[d - w];
      end
    end
    return prod[63:0];
  endfunction

  // x^e mod (x^w + x^tap + 1): coefficients give a[t+e] in terms of a[t..t+w-1]
  function automatic gfPoly powX(longint unsigned e, int w, int tap);
    gfPoly acc;
    gfPoly base;
    acc  = 64'd1;
    base = 64'd2;
    for (int b = 0; b < 64; b++) begin
      if (e[b]) acc = mulMod(acc, base, w, tap);
      base = mulMod(base, base, w, tap);
    end
    return acc;
  endfunction

endpackage

// File: rtl/dither_lfsr_ctrl.sv
module dither_lfsr_ctrl
  import dither_lfsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        seedLoad,
  output lfsrStrobe_t strobes,
  output logic        validQ
);

  always_comb begin
    strobes.loadSeed = seedLoad;
    strobes.advance  = enable & ~seedLoad;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= strobes.advance;
  end

endmodule

// File: rtl/dither_lfsr_dp.sv
module dither_lfsr_dp
  import dither_lfsr_pkg::*;
#(
  parameter int WIDTH = 23,
  parameter int TAP   = 18,
  parameter int LANES = 7,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst,
  input  lfsrStrobe_t      strobes,
  input  logic [WIDTH-1:0] seedIn,
  output logic [LANES-1:0] wordQ
);

  localparam longint unsigned PERIOD = (64'd1 << WIDTH) - 64'd1;
  localparam longint unsigned STRIDE = PERIOD / LANES;

  logic [WIDTH-1:0] stateQ;
  logic [WIDTH-1:0] stateNext;
  logic [WIDTH-1:0] loadVal;
  logic [LANES-1:0] laneBits;

  always_comb begin
    loadVal   = (seedIn == '0) ? DEFAULT_SEED : seedIn;
    stateNext = {stateQ[0] ^ stateQ[TAP], stateQ[WIDTH-1:1]};
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam gfPoly LANE_MASK = powX(longint'(g) * STRIDE, WIDTH, TAP);
    assign laneBits[g] = ^(stateQ & LANE_MASK[WIDTH-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= DEFAULT_SEED;
      wordQ  <= '0;
    end else if (strobes.loadSeed) begin
      stateQ <= loadVal;
    end else if (strobes.advance) begin
      stateQ <= stateNext;
      wordQ  <= laneBits;
    end
  end

endmodule

// File: rtl/dither_lfsr.sv
module dither_lfsr
  import dither_lfsr_pkg::*;
#(
  parameter int WIDTH = 23,
  parameter int TAP   = 18,
  parameter int LANES = 7,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             seedLoad,
  input  logic [WIDTH-1:0] seedIn,
  output logic [LANES-1:0] ditherWord,
  output logic             ditherValid
);

  lfsrStrobe_t strobes;

  dither_lfsr_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .seedLoad (seedLoad),
    .strobes  (strobes),
    .validQ   (ditherValid)
  );

  dither_lfsr_dp #(
    .WIDTH        (WIDTH),
    .TAP          (TAP),
    .LANES        (LANES),
    .DEFAULT_SEED (DEFAULT_SEED)
  ) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .seedIn  (seedIn),
    .wordQ   (ditherWord)
  );

endmodule

// File: rtl/dither_lfsr_chk.sv
module dither_lfsr_chk #(
  parameter int WIDTH = 23,
  parameter int TAP   = 18,
  parameter int LANES = 7,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = WIDTH'(1)
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             seedLoad,
  input logic [WIDTH-1:0] seedIn,
  input logic [LANES-1:0] ditherWord,
  input logic             ditherValid,
  input logic [WIDTH-1:0] stateQ
);

  a_r6_valid_after_step: assert property (@(posedge clk) disable iff (rst)
    (enable && !seedLoad) |=> ditherValid);

  a_r5_no_valid_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!enable || seedLoad) |=> !ditherValid);

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!enable && !seedLoad) |=> ($stable(stateQ) && $stable(ditherWord)));

  a_r2_lane0_is_state_bit: assert property (@(posedge clk) disable iff (rst)
    (enable && !seedLoad) |=> (ditherWord[0] == $past(stateQ[0])));

  a_r7_seed_copied: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedIn != '0) |=> (stateQ == $past(seedIn)));

  a_r8_zero_seed_default: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedIn == '0) |=> (stateQ == DEFAULT_SEED));

  a_r9_state_nonzero: assert property (@(posedge clk) disable iff (rst)
    stateQ != '0);

endmodule

bind dither_lfsr dither_lfsr_chk #(
  .WIDTH        (WIDTH),
  .TAP          (TAP),
  .LANES        (LANES),
  .DEFAULT_SEED (DEFAULT_SEED)
) uChk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .seedLoad    (seedLoad),
  .seedIn      (seedIn),
  .ditherWord  (ditherWord),
  .ditherValid (ditherValid),
  .stateQ      (uDp.stateQ)
);

// File: tb/dither_lfsr_test.sv
module dither_lfsr_test;

  localparam int unsigned STRIDE_MAIN  = 1198372;
  localparam int unsigned STRIDE_SMALL = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, ld = 1'b0;
  logic [22:0] seed = '0;
  logic [6:0] word;
  logic vld;

  logic enS = 1'b0, ldS = 1'b0;
  logic [6:0] seedS = '0;
  logic [6:0] wordS;
  logic vldS;

  int checks = 0;
  int errors = 0;

  logic [31:0] refLane [7];
  logic [6:0] expQ [$];
  logic [6:0] smallWords [160];

  always #10 clk = ~clk;

  dither_lfsr uut (
    .clk(clk), .rst(rst), .enable(en), .seedLoad(ld), .seedIn(seed),
    .ditherWord(word), .ditherValid(vld)
  );

  dither_lfsr #(.WIDTH(7), .TAP(6), .LANES(7), .DEFAULT_SEED(7'd1)) uutSmall (
    .clk(clk), .rst(rst), .enable(enS), .seedLoad(ldS), .seedIn(seedS),
    .ditherWord(wordS), .ditherValid(vldS)
  );

  function automatic logic [31:0] stepRef(logic [31:0] s, int w, int tap);
    logic nb;
    nb = s[0] ^ s[tap];
    s = s >> 1;
    s[w-1] = nb;
    return s;
  endfunction

  function automatic logic [31:0] advRef(logic [31:0] s, int w, int tap, int unsigned n);
    for (int unsigned k = 0; k < n; k++) s = stepRef(s, w, tap);
    return s;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic seedModel(logic [31:0] s);
    refLane[0] = s;
    for (int i = 1; i < 7; i++) refLane[i] = advRef(refLane[i-1], 23, 18, STRIDE_MAIN);
  endtask

  function automatic logic [6:0] expWord();
    logic [6:0] r;
    for (int i = 0; i < 7; i++) r[i] = refLane[i][0];
    return r;
  endfunction

  task automatic stepModel();
    for (int i = 0; i < 7; i++) refLane[i] = stepRef(refLane[i], 23, 18);
  endtask

  // Monitor: pops the expected word for every valid output
  always @(negedge clk) begin
    if (!rst && vld) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6", "valid without pending step", {25'b0, word}, 32'h0);
      end else begin
        logic [6:0] e;
        e = expQ.pop_front();
        check(word == e, "R3", "lane word", {25'b0, word}, {25'b0, e});
        check(word[0] == e[0], "R2", "lane 0 bit", {31'b0, word[0]}, {31'b0, e[0]});
      end
    end
  end

  // Driver tasks
  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      en = 1'b1; ld = 1'b0;
      expQ.push_back(expWord());
      stepModel();
    end
  endtask

  task automatic stepOnce();
    @(negedge clk);
    en = 1'b1; ld = 1'b0;
    expQ.push_back(expWord());
    stepModel();
    @(negedge clk);
    en = 1'b0;
    check(vld == 1'b1, "R6", "valid after single step", {31'b0, vld}, 32'h1);
  endtask

  task automatic idle(int n);
    logic [6:0] held;
    @(negedge clk);
    en = 1'b0; ld = 1'b0;
    held = word;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(vld == 1'b0, "R5", "valid while idle", {31'b0, vld}, 32'h0);
      check(word == held, "R5", "word held while idle", {25'b0, word}, {25'b0, held});
    end
  endtask

  task automatic loadSeed(logic [22:0] s, logic withEn);
    @(negedge clk);
    ld = 1'b1; en = withEn; seed = s;
    seedModel((s == '0) ? 32'd1 : {9'b0, s});
    @(negedge clk);
    ld = 1'b0; en = 1'b0;
    check(vld == 1'b0, "R7", "valid low after load", {31'b0, vld}, 32'h0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [6:0] e;
    logic [31:0] sRef [7];
    int idx;

    seedModel(32'd1);
    repeat (3) @(negedge clk);
    check(vld == 1'b0, "R1", "valid in reset", {31'b0, vld}, 32'h0);
    check(word == 7'd0, "R1", "word in reset", {25'b0, word}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(vld == 1'b0, "R1", "valid after reset", {31'b0, vld}, 32'h0);
    check(word == 7'd0, "R1", "word after reset", {25'b0, word}, 32'h0);

    // R1: first word after reset comes from the default seed
    e = expWord();
    run(1);
    @(negedge clk);
    en = 1'b0;
    check(word == e, "R1", "first word from default seed", {25'b0, word}, {25'b0, e});
    run(40);
    idle(5);
    for (int k = 0; k < 12; k++) begin
      stepOnce();
      idle(1);
    end
    run(30);

    // R7: load while enable is high
    loadSeed(23'h2B5C91, 1'b1);
    run(200);
    idle(2);

    // R8: zero seed maps to default
    loadSeed(23'h0, 1'b0);
    e = expWord();
    run(1);
    @(negedge clk);
    en = 1'b0;
    check(word == e, "R8", "word after zero seed", {25'b0, word}, {25'b0, e});
    run(25);

    loadSeed(23'h7FFFFF, 1'b0);
    run(60);
    idle(3);

    // R4: full period on the 7-bit instance
    @(negedge clk);
    ldS = 1'b1; seedS = 7'h35;
    @(negedge clk);
    ldS = 1'b0;
    idx = 0;
    for (int j = 0; j < 150; j++) begin
      @(negedge clk);
      enS = 1'b1;
      if (vldS && idx < 160) begin
        smallWords[idx] = wordS;
        idx++;
      end
    end
    @(negedge clk);
    enS = 1'b0;
    check(idx >= 147, "R6", "small instance word count", idx, 147);
    for (int j = 0; j < 20; j++) begin
      check(smallWords[j] == smallWords[j + 127], "R4", "word repeats after 127 steps",
            {25'b0, smallWords[j + 127]}, {25'b0, smallWords[j]});
    end
    // R3 on the narrow instance: lanes offset by 18 steps
    sRef[0] = 32'h35;
    for (int i = 1; i < 7; i++) sRef[i] = advRef(sRef[i-1], 7, 6, STRIDE_SMALL);
    for (int j = 0; j < 10; j++) begin
      for (int i = 0; i < 7; i++) e[i] = sRef[i][0];
      check(smallWords[j] == e, "R3", "narrow lane word", {25'b0, smallWords[j]}, {25'b0, e});
      for (int i = 0; i < 7; i++) sRef[i] = stepRef(sRef[i], 7, 6);
    end

    check(expQ.size() == 0, "R6", "all steps produced words", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule